// File: doc/BRIEF.md
# Interrupt Destination Router

This block sits after the pending/enable stage of an interrupt controller. It takes one level per interrupt source that is already pending and enabled, and delivers it to exactly one target processor. On that processor it drives one of three request kinds: one of 64 ordinary interrupt pins, the non-maskable interrupt (NMI) line, or an auxiliary event line. Each processor gets a 64-bit pin request vector, an NMI request and an auxiliary event request. Every output is the OR of all active sources that are routed to it, registered once.

Software programs two map registers per source through a plain 32-bit register port. The destination map picks the delivery kind and the pin number. The processor map holds a one-hot processor choice. Source levels are plain level signals. They are not a stream, so the port has no handshake and no back-pressure: a level that is high at a clock edge is reflected at the outputs after that edge, and a level that falls is withdrawn the same way. The register port writes on any cycle with `cfg_wr_en` high. Read data is combinational from `cfg_addr`.

Top module: `irq_route_unit`

## Requirements
- R1: After reset every output is 0 and every map register reads 0, which means "not routed".
- R2: The destination map of source n is at byte address 0x500 + 4*n. Bit 31 selects pin delivery, bit 30 selects NMI, bit 29 selects the auxiliary event line, and bits 5:0 hold the pin number. These bits read back as last written; all other bits read 0.
- R3: The processor map of source n is at byte address 0x2000 + 32*n + 4*w. Processor v is bit (v mod 32) of word w = v/32.
- R4: A processor-map write replaces the whole selection with the lowest-numbered processor whose bit is set, so reads return a one-hot value. Writing 0 removes the selection.
- R5: With only bit 31 of the destination map set, an active source raises bit p*64+k of `cpu_pin_o`, where p is the selected processor and k is the pin number (0..63).
- R6: With bit 30 set, the source raises `cpu_nmi_o[p]` and nothing else. NMI beats the auxiliary event line, which beats pin delivery.
- R7: With bit 29 set and bit 30 clear, the source raises `cpu_evt_o[p]` and no pin.
- R8: A source whose destination map has none of bits 31, 30 or 29 set, or which has no processor selected, drives no output.
- R9: Each output is the OR of all active sources routed to it. Outputs follow the source levels with one clock cycle of latency, for both rising and falling levels.
- R10: A write to an address outside both map ranges is ignored and that address reads 0. This includes a processor-map word whose index is at or beyond the number of processor-map words (any word above 0 with 32 processors). Such a write leaves routing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_active_i | input | NUM_IRQ | Pending-and-enabled level per source |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Byte address of the register access |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr` (combinational) |
| cpu_pin_o | output | NUM_CPU*64 | Pin requests, bit p*64+k is pin k of processor p |
| cpu_nmi_o | output | NUM_CPU | NMI request per processor |
| cpu_evt_o | output | NUM_CPU | Auxiliary event request per processor |

## Verification
The hardest cases to reach are the ones where one register word carries several competing choices. These are a destination map with two or three kind bits set together, a processor-map write with several bits set, and two sources that land on the same pin of the same processor. The stimulus writes exactly such words (all three kind bits, or two processor bits). It then raises overlapping sources and drops them one at a time, which shows that the merge and the priority hold and that the one-cycle withdrawal works. The top pin of the top processor and an out-of-range processor-map word are also driven, to cover the edges of the decoding.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int PIN_W    = 6;
  localparam int NUM_PINS = 1 << PIN_W;

  localparam logic [31:0] DEST_MAP_BASE   = 32'h0000_0500;
  localparam logic [31:0] CPU_MAP_BASE    = 32'h0000_2000;
  localparam int          CPU_MAP_STRIDE  = 32;
  localparam logic [31:0] DEST_KEEP_MASK  = 32'hE000_003F;

  typedef enum logic [1:0] {
    DEST_NONE = 2'd0,
    DEST_PIN  = 2'd1,
    DEST_NMI  = 2'd2,
    DEST_EVT  = 2'd3
  } dest_kind_e;

  typedef struct packed {
    logic             to_pin;
    logic             to_nmi;
    logic             to_evt;
    logic [PIN_W-1:0] pin;
  } dest_map_t;

  function automatic dest_map_t pack_dest(input logic [31:0] w);
    dest_map_t m;
    m.to_pin = w[31];
    m.to_nmi = w[30];
    m.to_evt = w[29];
    m.pin    = w[PIN_W-1:0];
    return m;
  endfunction

  function automatic logic [31:0] unpack_dest(input dest_map_t m);
    return {m.to_pin, m.to_nmi, m.to_evt, {(29-PIN_W){1'b0}}, m.pin};
  endfunction

  // NMI first, auxiliary event second, ordinary pin last
  function automatic dest_kind_e classify(input dest_map_t m);
    if (m.to_nmi)      return DEST_NMI;
    else if (m.to_evt) return DEST_EVT;
    else if (m.to_pin) return DEST_PIN;
    else               return DEST_NONE;
  endfunction
endpackage

// File: rtl/irq_map_regs.sv
module irq_map_regs
  import irq_route_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int NUM_CPU = 32,
  parameter int ADDR_W  = 14
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [31:0]                       wdata,
  output logic [31:0]                       rdata,
  output dest_map_t [NUM_IRQ-1:0]           dest_map_o,
  output logic [NUM_IRQ-1:0][NUM_CPU-1:0]   cpu_sel_o
);
  localparam int CPU_WORDS = (NUM_CPU + 31) / 32;
  localparam int PAD_W     = CPU_WORDS * 32;
  localparam int IRQ_W     = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  dest_map_t [NUM_IRQ-1:0]         dest_q;
  logic [NUM_IRQ-1:0][NUM_CPU-1:0] sel_q;

  logic [31:0]      a32, dest_off, cpu_off, cpu_word;
  logic             dest_hit, cpu_area, cpu_hit;
  logic [IRQ_W-1:0] dest_idx, cpu_idx;

  assign a32      = 32'(addr);
  assign dest_off = a32 - DEST_MAP_BASE;
  assign cpu_off  = a32 - CPU_MAP_BASE;
  assign dest_hit = (a32 >= DEST_MAP_BASE) && (dest_off < 32'(4 * NUM_IRQ));
  assign dest_idx = dest_off[IRQ_W+1:2];
  assign cpu_area = (a32 >= CPU_MAP_BASE) && (cpu_off < 32'(CPU_MAP_STRIDE * NUM_IRQ));
  assign cpu_word = 32'(cpu_off[4:2]);
  assign cpu_hit  = cpu_area && (cpu_word < 32'(CPU_WORDS));
  assign cpu_idx  = cpu_off[IRQ_W+4:5];

  // place the written word at its processor offset, keep only the lowest bit
  logic [PAD_W-1:0]   placed;
  logic [NUM_CPU-1:0] cand, sel_new;
  always_comb begin
    placed = '0;
    for (int w = 0; w < CPU_WORDS; w++) begin
      if (cpu_word == w) placed[w*32 +: 32] = wdata;
    end
    cand    = placed[NUM_CPU-1:0];
    sel_new = cand & (-cand);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dest_q <= '0;
      sel_q  <= '0;
    end else if (wr_en) begin
      if (dest_hit) dest_q[dest_idx] <= pack_dest(wdata);
      if (cpu_hit)  sel_q[cpu_idx]   <= sel_new;
    end
  end

  logic [PAD_W-1:0] sel_pad;
  always_comb begin
    rdata   = '0;
    sel_pad = '0;
    sel_pad[NUM_CPU-1:0] = sel_q[cpu_idx];
    if (dest_hit) begin
      rdata = unpack_dest(dest_q[dest_idx]);
    end else if (cpu_hit) begin
      for (int w = 0; w < CPU_WORDS; w++) begin
        if (cpu_word == w) rdata = sel_pad[w*32 +: 32];
      end
    end
  end

  assign dest_map_o = dest_q;
  assign cpu_sel_o  = sel_q;
endmodule

// File: rtl/irq_dest_decode.sv
module irq_dest_decode
  import irq_route_pkg::*;
#(
  parameter int NUM_IRQ = 32
) (
  input  dest_map_t [NUM_IRQ-1:0]           dest_map_i,
  input  logic [NUM_IRQ-1:0]                active_i,
  output logic [NUM_IRQ-1:0][NUM_PINS-1:0]  pin_req_o,
  output logic [NUM_IRQ-1:0]                nmi_req_o,
  output logic [NUM_IRQ-1:0]                evt_req_o
);
  localparam logic [NUM_PINS-1:0] PIN_ONE = {{(NUM_PINS-1){1'b0}}, 1'b1};

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_src
    dest_kind_e kind;
    assign kind         = active_i[g] ? classify(dest_map_i[g]) : DEST_NONE;
    assign nmi_req_o[g] = (kind == DEST_NMI);
    assign evt_req_o[g] = (kind == DEST_EVT);
    assign pin_req_o[g] = (kind == DEST_PIN) ? (PIN_ONE << dest_map_i[g].pin) : '0;
  end
endmodule

// File: rtl/irq_fanout.sv
module irq_fanout #(
  parameter int NUM_IRQ  = 32,
  parameter int NUM_CPU  = 32,
  parameter int NUM_PINS = 64
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_IRQ-1:0][NUM_PINS-1:0]   pin_req_i,
  input  logic [NUM_IRQ-1:0]                 nmi_req_i,
  input  logic [NUM_IRQ-1:0]                 evt_req_i,
  input  logic [NUM_IRQ-1:0][NUM_CPU-1:0]    cpu_sel_i,
  output logic [NUM_CPU*NUM_PINS-1:0]        cpu_pin_o,
  output logic [NUM_CPU-1:0]                 cpu_nmi_o,
  output logic [NUM_CPU-1:0]                 cpu_evt_o
);
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [NUM_PINS-1:0] pin_nx, pin_q;
    logic                nmi_nx, nmi_q, evt_nx, evt_q;

    always_comb begin
      pin_nx = '0;
      nmi_nx = 1'b0;
      evt_nx = 1'b0;
      for (int i = 0; i < NUM_IRQ; i++) begin
        if (cpu_sel_i[i][c]) begin
          pin_nx = pin_nx | pin_req_i[i];
          nmi_nx = nmi_nx | nmi_req_i[i];
          evt_nx = evt_nx | evt_req_i[i];
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pin_q <= '0;
        nmi_q <= 1'b0;
        evt_q <= 1'b0;
      end else begin
        pin_q <= pin_nx;
        nmi_q <= nmi_nx;
        evt_q <= evt_nx;
      end
    end

    assign cpu_pin_o[c*NUM_PINS +: NUM_PINS] = pin_q;
    assign cpu_nmi_o[c] = nmi_q;
    assign cpu_evt_o[c] = evt_q;
  end
endmodule

// File: rtl/irq_route_unit.sv
module irq_route_unit
  import irq_route_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int NUM_CPU = 32,
  parameter int ADDR_W  = 14
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_IRQ-1:0]          irq_active_i,
  input  logic                        cfg_wr_en,
  input  logic [ADDR_W-1:0]           cfg_addr,
  input  logic [31:0]                 cfg_wdata,
  output logic [31:0]                 cfg_rdata,
  output logic [NUM_CPU*NUM_PINS-1:0] cpu_pin_o,
  output logic [NUM_CPU-1:0]          cpu_nmi_o,
  output logic [NUM_CPU-1:0]          cpu_evt_o
);
  dest_map_t [NUM_IRQ-1:0]          dest_map;
  logic [NUM_IRQ-1:0][NUM_CPU-1:0]  cpu_sel;
  logic [NUM_IRQ-1:0][NUM_PINS-1:0] pin_req;
  logic [NUM_IRQ-1:0]               nmi_req, evt_req;

  irq_map_regs #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .dest_map_o(dest_map), .cpu_sel_o(cpu_sel)
  );

  irq_dest_decode #(.NUM_IRQ(NUM_IRQ)) u_decode (
    .dest_map_i(dest_map), .active_i(irq_active_i),
    .pin_req_o(pin_req), .nmi_req_o(nmi_req), .evt_req_o(evt_req)
  );

  irq_fanout #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .NUM_PINS(NUM_PINS)) u_fanout (
    .clk(clk), .rst_n(rst_n), .pin_req_i(pin_req), .nmi_req_i(nmi_req),
    .evt_req_i(evt_req), .cpu_sel_i(cpu_sel),
    .cpu_pin_o(cpu_pin_o), .cpu_nmi_o(cpu_nmi_o), .cpu_evt_o(cpu_evt_o)
  );
endmodule

// File: rtl/irq_route_unit_chk.sv
module irq_route_unit_chk
  import irq_route_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int NUM_CPU = 32,
  parameter int ADDR_W  = 14
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NUM_IRQ-1:0]          irq_active_i,
  input logic                        cfg_wr_en,
  input logic [ADDR_W-1:0]           cfg_addr,
  input logic [31:0]                 cfg_wdata,
  input logic [31:0]                 cfg_rdata,
  input logic [NUM_CPU*NUM_PINS-1:0] cpu_pin_o,
  input logic [NUM_CPU-1:0]          cpu_nmi_o,
  input logic [NUM_CPU-1:0]          cpu_evt_o
);
  logic [31:0] a32;
  logic        dest_hit, cpu_hit;
  assign a32      = 32'(cfg_addr);
  assign dest_hit = (a32 >= DEST_MAP_BASE) && (a32 < DEST_MAP_BASE + 32'(4 * NUM_IRQ));
  assign cpu_hit  = (a32 >= CPU_MAP_BASE) && (a32 < CPU_MAP_BASE + 32'(CPU_MAP_STRIDE * NUM_IRQ));

  // R9: no active source in one cycle, no request of any kind in the next
  assert_quiet_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_active_i == '0) |=> (cpu_pin_o == '0 && cpu_nmi_o == '0 && cpu_evt_o == '0));

  // R6: each source lands on at most one output bit
  assert_single_destination_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({cpu_pin_o, cpu_nmi_o, cpu_evt_o}) <= $past($countones(irq_active_i)));

  // R2: destination map reads back the kept bits of the last write
  assert_dest_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && dest_hit) |=>
      (cfg_wr_en || cfg_addr != $past(cfg_addr) ||
       cfg_rdata == ($past(cfg_wdata) & DEST_KEEP_MASK)));

  // R4: processor map never holds more than one processor
  assert_cpu_sel_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && cpu_hit) |=>
      (cfg_wr_en || cfg_addr != $past(cfg_addr) || $onehot0(cfg_rdata)));
endmodule

bind irq_route_unit irq_route_unit_chk #(
  .NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_active_i(irq_active_i), .cfg_wr_en(cfg_wr_en),
  .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
  .cpu_pin_o(cpu_pin_o), .cpu_nmi_o(cpu_nmi_o), .cpu_evt_o(cpu_evt_o)
);

// File: tb/irq_route_unit_test.sv
module irq_route_unit_test;
  localparam int NI = 32;
  localparam int NC = 32;
  localparam int NP = 64;
  localparam int AW = 14;
  localparam int PW = NC * NP;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NI-1:0] irq_active = '0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [PW-1:0] pin_o;
  logic [NC-1:0] nmi_o, evt_o;

  always #4 clk = ~clk;

  irq_route_unit #(.NUM_IRQ(NI), .NUM_CPU(NC), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .irq_active_i(irq_active), .cfg_wr_en(wr_en),
    .cfg_addr(addr), .cfg_wdata(wdata), .cfg_rdata(rdata),
    .cpu_pin_o(pin_o), .cpu_nmi_o(nmi_o), .cpu_evt_o(evt_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // requirement model
  logic [31:0] dest_m [NI];
  int          sel_m  [NI];

  logic [PW-1:0] exp_pin_q [$];
  logic [NC-1:0] exp_nmi_q [$];
  logic [NC-1:0] exp_evt_q [$];
  string         tag_q     [$];

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_dest(input int n, input logic [31:0] d);
    wr(32'h500 + 32'(4 * n), d);
    dest_m[n] = d & 32'hE000_003F;
  endtask

  task automatic set_cpu(input int n, input logic [31:0] d);
    wr(32'h2000 + 32'(32 * n), d);
    sel_m[n] = -1;
    for (int b = 31; b >= 0; b--) if (d[b]) sel_m[n] = b;
  endtask

  task automatic rd_check(input logic [31:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr = AW'(a);
    #1;
    checks++;
    if (rdata !== exp) begin
      fails++;
      $display("FAIL %s read %h: actual %h expected %h", tag, a, rdata, exp);
    end
  endtask

  task automatic drive(input logic [NI-1:0] act, input string tag);
    logic [PW-1:0] ep;
    logic [NC-1:0] en, ee;
    ep = '0; en = '0; ee = '0;
    for (int i = 0; i < NI; i++) begin
      if (act[i] && sel_m[i] >= 0) begin
        if (dest_m[i][30])      en[sel_m[i]] = 1'b1;
        else if (dest_m[i][29]) ee[sel_m[i]] = 1'b1;
        else if (dest_m[i][31]) ep[sel_m[i]*NP + int'(dest_m[i][5:0])] = 1'b1;
      end
    end
    @(negedge clk);
    irq_active = act;
    exp_pin_q.push_back(ep);
    exp_nmi_q.push_back(en);
    exp_evt_q.push_back(ee);
    tag_q.push_back(tag);
  endtask

  // monitor: compares one edge after each drive
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (tag_q.size() > 0) begin
        logic [PW-1:0] ep;
        logic [NC-1:0] en, ee;
        string t;
        ep = exp_pin_q.pop_front();
        en = exp_nmi_q.pop_front();
        ee = exp_evt_q.pop_front();
        t  = tag_q.pop_front();
        checks++;
        if (pin_o !== ep || nmi_o !== en || evt_o !== ee) begin
          fails++;
          $display("FAIL %s: actual pin=%h nmi=%h evt=%h expected pin=%h nmi=%h evt=%h",
                   t, pin_o, nmi_o, evt_o, ep, en, ee);
        end
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NI; i++) begin dest_m[i] = '0; sel_m[i] = -1; end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    drive('0, "R1 outputs after reset");
    rd_check(32'h500, 32'h0, "R1 dest map reset");
    rd_check(32'h23E0, 32'h0, "R1 cpu map reset");

    // R2: kept bits only
    set_dest(3, 32'h9234_0005);
    rd_check(32'h50C, 32'h8000_0005, "R2 dest readback");
    // R3/R4: two bits written, lowest (cpu 4) kept
    set_cpu(3, 32'h0000_0050);
    rd_check(32'h2060, 32'h0000_0010, "R4 lowest bit wins");
    drive(32'h0000_0008, "R5 pin 5 of cpu 4");

    // R6: all three kind bits, NMI wins, cpu 31
    set_dest(7, 32'hE000_0000);
    set_cpu(7, 32'h8000_0000);
    rd_check(32'h20E0, 32'h8000_0000, "R3 cpu 31 readback");
    drive(32'h0000_0080, "R6 nmi priority");

    // R7: event beats pin
    set_dest(8, 32'hA000_0003);
    set_cpu(8, 32'h0000_0001);
    drive(32'h0000_0100, "R7 event over pin");

    // R8: no kind bit; no processor
    set_dest(9, 32'h0000_0005);
    set_cpu(9, 32'h0000_0004);
    set_dest(10, 32'h8000_0001);
    drive(32'h0000_0600, "R8 undelivered sources");

    // R9: merge and withdrawal
    set_dest(11, 32'h8000_0005);
    set_cpu(11, 32'h0000_0010);
    drive(32'h0000_0808, "R9 two sources same pin");
    drive(32'h0000_0800, "R9 one source dropped");
    drive(32'h0000_0000, "R9 all withdrawn");
    drive(32'h0000_0988, "R9 mixed kinds");

    // R4: replacement and clear
    set_cpu(3, 32'h0000_0001);
    rd_check(32'h2060, 32'h0000_0001, "R4 replaced");
    drive(32'h0000_0008, "R4 moved to cpu 0");
    set_cpu(3, 32'h0000_0000);
    rd_check(32'h2060, 32'h0000_0000, "R4 cleared");
    drive(32'h0000_0008, "R4 cleared not routed");

    // R10: writes outside the map ranges
    wr(32'h2164, 32'hFFFF_FFFF);
    rd_check(32'h2164, 32'h0, "R10 cpu word 1");
    rd_check(32'h2160, 32'h0000_0010, "R10 word 0 intact");
    drive(32'h0000_0800, "R10 routing unchanged");
    wr(32'h580, 32'hFFFF_FFFF);
    rd_check(32'h580, 32'h0, "R10 past dest range");
    wr(32'h4FC, 32'hFFFF_FFFF);
    rd_check(32'h4FC, 32'h0, "R10 below dest range");
    rd_check(32'h500, 32'h0, "R10 dest 0 intact");

    // R5 boundary: top pin on top processor
    set_dest(31, 32'h8000_003F);
    set_cpu(31, 32'h8000_0000);
    drive(32'h8000_0000, "R5 pin 63 of cpu 31");
    drive(32'hFFFF_FFFF, "R9 all sources");
    drive(32'h0000_0000, "R9 final idle");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule